// File: doc/BRIEF.md
# Host/Controller Mailbox with Circular Command and Response Rings

This block sits between a host processor and a management controller. It has two circular rings of 32-bit words. The host fills the command ring and then publishes its producer index. The controller drains that ring and advances the consumer index. In the other direction, the controller pushes response words and advances the producer index of the response ring. The host reads those words and advances the consumer index. The host reaches everything through a simple single-cycle register bus. Read data is combinational on the address, and a read strobe marks a read that has side effects.

Besides the rings, the block holds several smaller registers:
- an urgent-command word that the controller sees directly;
- a three-bit interrupt-enable register;
- a status word whose urgent-acknowledge bit flips each time the controller acknowledges an urgent command;
- one single-bit doorbell in each direction.

Three events are latched: the controller moved the command consumer index, the controller moved the response producer index, and the urgent acknowledge flipped. Any latched event that is also enabled raises the interrupt line.

Top module: `mbox_regfile`

## Requirements
- R1: After reset, every index, both doorbells, the enable register and the urgent word read as zero. The status word reads 0 and `irq` is low.
- R2: A host write to the command producer index (0x00) stores the written value modulo 32. A host write to the response consumer index (0x04) stores it modulo 16.
- R3: The command consumer index (0x20) and the response producer index (0x24) are read-only from the host. Host writes to them leave them unchanged.
- R4: A host write to 0x40+4*i stores command word i. `c_cmd_avail` is high when the producer index differs from the consumer index, and `c_cmd_word` presents the word at the consumer index. `c_cmd_pop` advances the consumer index modulo 32. A pop while the ring is empty is ignored.
- R5: `c_rsp_push` writes `c_rsp_word` at the response producer index and advances that index modulo 16. The host reads word i at 0xC0+4*i. `c_rsp_room` is low when (producer+1) mod 16 equals the consumer index, and a push in that state is ignored.
- R6: The status word (0x2C) has three bits. Bit 0 is high when (command producer+1) mod 32 equals the command consumer index. Bit 1 is high when the response producer and consumer indices differ. Bit 8 is the urgent acknowledge, which inverts once per `c_urg_ack` pulse.
- R7: The enable register (0x0C) keeps only bits 0 (command consumer moved), 1 (response producer moved) and 8 (urgent acknowledge). All other bits read 0.
- R8: Bit 0 of the doorbell at 0x400 is written by the host and drives `c_doorbell`. `c_db_clr` clears it.
- R9: `c_db_set` sets bit 0 of the doorbell at 0x480, and a host write of 0 clears it.
- R10: Each event is latched when it occurs, and `irq` is the OR of the latched events that are enabled. A host read of status (strobed by `h_rd`) clears all three events. A host write to 0x00 clears the command-consumer event, and a host write to 0x04 clears the response-producer event. A new event in the same cycle as a clear wins.
- R11: The urgent word (0x08) stores all 32 bits and drives `c_urgent`.
- R12: Unmapped addresses and the command word region read as 0. Host writes into the response word region are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 12 | Host byte address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (side effects only) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational on h_addr |
| irq | output | 1 | Interrupt to the host |
| c_cmd_word | output | 32 | Command word at the consumer index |
| c_cmd_avail | output | 1 | Command ring not empty |
| c_cmd_pop | input | 1 | Controller consumes one command word |
| c_rsp_word | input | 32 | Response word to push |
| c_rsp_push | input | 1 | Controller pushes one response word |
| c_rsp_room | output | 1 | Response ring can accept a word |
| c_urgent | output | 32 | Urgent word contents |
| c_urg_ack | input | 1 | Controller acknowledges the urgent command |
| c_db_set | input | 1 | Controller rings the host doorbell |
| c_doorbell | output | 1 | Doorbell toward the controller |
| c_db_clr | input | 1 | Controller clears its doorbell |

## Verification
The bench builds the block with its default parameters: a 32-word command ring, a 16-word response ring and a 12-bit address. With these sizes a full lap of each ring takes only a few dozen pulses. Because of that, the full condition, the wrap back to index zero and the ignored pop and push at the ring limits can all be reached directly. The offsets at 0x400 and 0x480 also fall within the 12-bit address, so both doorbells are reached through the same bus path as the index registers.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned WORD_W = 32;

  // event slots in the interrupt latch
  localparam int unsigned EV_CMD_FREED = 0;
  localparam int unsigned EV_RSP_ADDED = 1;
  localparam int unsigned EV_URG_FLIP  = 2;
  localparam int unsigned EV_COUNT     = 3;

  function automatic int unsigned ring_wrap(input int unsigned value, input int unsigned depth);
    return value % depth;
  endfunction

  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx + 1) % depth;
  endfunction

  function automatic logic ring_full(input int unsigned prod, input int unsigned cons,
                                     input int unsigned depth);
    return ring_next(prod, depth) == cons;
  endfunction

  function automatic logic ring_empty(input int unsigned prod, input int unsigned cons);
    return prod == cons;
  endfunction

endpackage

// File: rtl/mbox_ring.sv
module mbox_ring
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_data,
  input  logic              prod_ld,
  input  logic [IW-1:0]     prod_val,
  input  logic              prod_inc,
  input  logic              cons_ld,
  input  logic [IW-1:0]     cons_val,
  input  logic              cons_inc,
  output logic [IW-1:0]     prod,
  output logic [IW-1:0]     cons,
  output logic              empty,
  output logic              full,
  output logic              stepped
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic              prod_step;
  logic              cons_step;
  logic [IW-1:0]     prod_nxt;
  logic [IW-1:0]     cons_nxt;

  assign full      = ring_full(32'(prod), 32'(cons), DEPTH);
  assign empty     = ring_empty(32'(prod), 32'(cons));
  assign prod_nxt  = IW'(ring_next(32'(prod), DEPTH));
  assign cons_nxt  = IW'(ring_next(32'(cons), DEPTH));
  assign prod_step = prod_inc && !full && !prod_ld;
  assign cons_step = cons_inc && !empty && !cons_ld;
  assign stepped   = prod_step || cons_step;
  assign rd_data   = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod <= '0;
      cons <= '0;
    end else begin
      if (prod_ld)        prod <= prod_val;
      else if (prod_step) prod <= prod_nxt;
      if (cons_ld)        cons <= cons_val;
      else if (cons_step) cons <= cons_nxt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_inc && full && !prod_ld) |=> (prod == $past(prod))); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_inc && empty && !cons_ld) |=> (cons == $past(cons))); // R4

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] pend,
  output logic         irq
);

  assign irq = |(pend & en);

  for (genvar g = 0; g < N; g++) begin : g_ev
    always_ff @(posedge clk) begin
      if (!rst_n)      pend[g] <= 1'b0;
      else if (set[g]) pend[g] <= 1'b1;
      else if (clr[g]) pend[g] <= 1'b0;
    end

    AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> pend[g]); // R10
  end

endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CMD_DEPTH = 32,
  parameter int unsigned RSP_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [WORD_W-1:0] h_wdata,
  output logic [WORD_W-1:0] h_rdata,
  output logic              irq,
  output logic [WORD_W-1:0] c_cmd_word,
  output logic              c_cmd_avail,
  input  logic              c_cmd_pop,
  input  logic [WORD_W-1:0] c_rsp_word,
  input  logic              c_rsp_push,
  output logic              c_rsp_room,
  output logic [WORD_W-1:0] c_urgent,
  input  logic              c_urg_ack,
  input  logic              c_db_set,
  output logic              c_doorbell,
  input  logic              c_db_clr
);

  localparam int unsigned CIW = $clog2(CMD_DEPTH);
  localparam int unsigned RIW = $clog2(RSP_DEPTH);

  localparam logic [ADDR_W-1:0] A_CMD_PROD = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_RSP_CONS = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_URGENT   = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_ENABLE   = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_CMD_CONS = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] A_RSP_PROD = ADDR_W'(12'h024);
  localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(12'h02C);
  localparam logic [ADDR_W-1:0] A_CMD_BASE = ADDR_W'(12'h040);
  localparam logic [ADDR_W-1:0] A_RSP_BASE = ADDR_W'(12'h0C0);
  localparam logic [ADDR_W-1:0] A_DB_OUT   = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] A_DB_IN    = ADDR_W'(12'h480);
  localparam logic [ADDR_W-1:0] CMD_SPAN   = ADDR_W'(CMD_DEPTH * 4);
  localparam logic [ADDR_W-1:0] RSP_SPAN   = ADDR_W'(RSP_DEPTH * 4);
  localparam int unsigned       UA_BIT     = 8;

  // decoded host strobes
  logic              sel_cmd_win, sel_rsp_win;
  logic [ADDR_W-1:0] cmd_off, rsp_off;
  logic              wr_cmd_prod, wr_rsp_cons, wr_cmd_word, rd_status;

  assign cmd_off     = h_addr - A_CMD_BASE;
  assign rsp_off     = h_addr - A_RSP_BASE;
  assign sel_cmd_win = (h_addr >= A_CMD_BASE) && (cmd_off < CMD_SPAN);
  assign sel_rsp_win = (h_addr >= A_RSP_BASE) && (rsp_off < RSP_SPAN);
  assign wr_cmd_prod = h_wr && (h_addr == A_CMD_PROD);
  assign wr_rsp_cons = h_wr && (h_addr == A_RSP_CONS);
  assign wr_cmd_word = h_wr && sel_cmd_win;
  assign rd_status   = h_rd && (h_addr == A_STATUS);

  // small registers
  logic [WORD_W-1:0] urgent_q;
  logic [2:0]        enable_q;
  logic              ua_q, db_out_q, db_in_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      urgent_q <= '0;
      enable_q <= '0;
      ua_q     <= 1'b0;
      db_out_q <= 1'b0;
      db_in_q  <= 1'b0;
    end else begin
      if (h_wr && h_addr == A_URGENT) urgent_q <= h_wdata;
      if (h_wr && h_addr == A_ENABLE) enable_q <= {h_wdata[UA_BIT], h_wdata[1:0]};
      if (c_urg_ack) ua_q <= !ua_q;
      if (h_wr && h_addr == A_DB_OUT) db_out_q <= h_wdata[0];
      else if (c_db_clr)              db_out_q <= 1'b0;
      if (c_db_set)                   db_in_q  <= 1'b1;
      else if (h_wr && h_addr == A_DB_IN) db_in_q <= h_wdata[0];
    end
  end

  // command ring: host produces, controller consumes
  logic [CIW-1:0] cmd_prod, cmd_cons;
  logic           cmd_empty, cmd_full, cmd_freed;

  mbox_ring #(.DEPTH(CMD_DEPTH), .IW(CIW)) u_cmd_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_cmd_word),
    .wr_idx   (cmd_off[CIW+1:2]),
    .wr_data  (h_wdata),
    .rd_idx   (cmd_cons),
    .rd_data  (c_cmd_word),
    .prod_ld  (wr_cmd_prod),
    .prod_val (CIW'(ring_wrap(h_wdata, CMD_DEPTH))),
    .prod_inc (1'b0),
    .cons_ld  (1'b0),
    .cons_val ('0),
    .cons_inc (c_cmd_pop),
    .prod     (cmd_prod),
    .cons     (cmd_cons),
    .empty    (cmd_empty),
    .full     (cmd_full),
    .stepped  (cmd_freed)
  );

  // response ring: controller produces, host consumes
  logic [RIW-1:0]    rsp_prod, rsp_cons;
  logic              rsp_empty, rsp_full, rsp_added;
  logic [WORD_W-1:0] rsp_rd_word;

  mbox_ring #(.DEPTH(RSP_DEPTH), .IW(RIW)) u_rsp_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (c_rsp_push && !rsp_full),
    .wr_idx   (rsp_prod),
    .wr_data  (c_rsp_word),
    .rd_idx   (rsp_off[RIW+1:2]),
    .rd_data  (rsp_rd_word),
    .prod_ld  (1'b0),
    .prod_val ('0),
    .prod_inc (c_rsp_push),
    .cons_ld  (wr_rsp_cons),
    .cons_val (RIW'(ring_wrap(h_wdata, RSP_DEPTH))),
    .cons_inc (1'b0),
    .prod     (rsp_prod),
    .cons     (rsp_cons),
    .empty    (rsp_empty),
    .full     (rsp_full),
    .stepped  (rsp_added)
  );

  // events and interrupt
  logic [EV_COUNT-1:0] ev_set, ev_clr, ev_en, ev_pend;

  always_comb begin
    ev_set = '0;
    ev_clr = '0;
    ev_en  = '0;
    ev_set[EV_CMD_FREED] = cmd_freed;
    ev_set[EV_RSP_ADDED] = rsp_added;
    ev_set[EV_URG_FLIP]  = c_urg_ack;
    ev_clr[EV_CMD_FREED] = rd_status || wr_cmd_prod;
    ev_clr[EV_RSP_ADDED] = rd_status || wr_rsp_cons;
    ev_clr[EV_URG_FLIP]  = rd_status;
    ev_en[EV_CMD_FREED]  = enable_q[0];
    ev_en[EV_RSP_ADDED]  = enable_q[1];
    ev_en[EV_URG_FLIP]   = enable_q[2];
  end

  mbox_irq #(.N(EV_COUNT)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_set),
    .clr   (ev_clr),
    .en    (ev_en),
    .pend  (ev_pend),
    .irq   (irq)
  );

  // outputs and read mux
  logic [WORD_W-1:0] status_word;

  assign c_cmd_avail = !cmd_empty;
  assign c_rsp_room  = !rsp_full;
  assign c_urgent    = urgent_q;
  assign c_doorbell  = db_out_q;

  always_comb begin
    status_word         = '0;
    status_word[0]      = cmd_full;
    status_word[1]      = !rsp_empty;
    status_word[UA_BIT] = ua_q;
  end

  always_comb begin
    h_rdata = '0;
    if (sel_rsp_win) h_rdata = rsp_rd_word;
    else begin
      case (h_addr)
        A_CMD_PROD: h_rdata = WORD_W'(cmd_prod);
        A_RSP_CONS: h_rdata = WORD_W'(rsp_cons);
        A_URGENT:   h_rdata = urgent_q;
        A_ENABLE:   h_rdata = {23'b0, enable_q[2], 6'b0, enable_q[1:0]};
        A_CMD_CONS: h_rdata = WORD_W'(cmd_cons);
        A_RSP_PROD: h_rdata = WORD_W'(rsp_prod);
        A_STATUS:   h_rdata = status_word;
        A_DB_OUT:   h_rdata = {31'b0, db_out_q};
        A_DB_IN:    h_rdata = {31'b0, db_in_q};
        default:    h_rdata = '0;
      endcase
    end
  end

  AST_UA_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    c_urg_ack |=> (ua_q != $past(ua_q))); // R6

  AST_DB_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    c_db_set |=> db_in_q); // R9

  AST_RSP_PROD_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == A_RSP_PROD && !c_rsp_push) |=> $stable(rsp_prod)); // R3

  AST_CMD_CONS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == A_CMD_CONS && !c_cmd_pop) |=> $stable(cmd_cons)); // R3

endmodule

// File: tb/mbox_regfile_tb.sv
module mbox_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] h_addr = '0;
  logic        h_wr = 1'b0;
  logic        h_rd = 1'b0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        irq;
  logic [31:0] c_cmd_word;
  logic        c_cmd_avail;
  logic        c_cmd_pop = 1'b0;
  logic [31:0] c_rsp_word = '0;
  logic        c_rsp_push = 1'b0;
  logic        c_rsp_room;
  logic [31:0] c_urgent;
  logic        c_urg_ack = 1'b0;
  logic        c_db_set = 1'b0;
  logic        c_doorbell;
  logic        c_db_clr = 1'b0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mbox_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .irq(irq),
    .c_cmd_word(c_cmd_word), .c_cmd_avail(c_cmd_avail), .c_cmd_pop(c_cmd_pop),
    .c_rsp_word(c_rsp_word), .c_rsp_push(c_rsp_push), .c_rsp_room(c_rsp_room),
    .c_urgent(c_urgent), .c_urg_ack(c_urg_ack), .c_db_set(c_db_set),
    .c_doorbell(c_doorbell), .c_db_clr(c_db_clr)
  );

  // {req[3:0], is_write, addr[11:0], data[31:0], expect[31:0]}
  localparam int NV = 14;
  localparam logic [80:0] VEC [NV] = '{
    {4'd2,  1'b1, 12'h000, 32'd33,        32'd0},         // R2 write producer 33
    {4'd2,  1'b0, 12'h000, 32'd0,         32'd1},         // R2 reads 33 mod 32
    {4'd2,  1'b1, 12'h004, 32'd17,        32'd0},         // R2 write consumer 17
    {4'd2,  1'b0, 12'h004, 32'd0,         32'd1},         // R2 reads 17 mod 16
    {4'd3,  1'b1, 12'h020, 32'd5,         32'd0},         // R3 write ignored
    {4'd3,  1'b0, 12'h020, 32'd0,         32'd0},         // R3
    {4'd3,  1'b1, 12'h024, 32'd7,         32'd0},         // R3 write ignored
    {4'd3,  1'b0, 12'h024, 32'd0,         32'd0},         // R3
    {4'd7,  1'b1, 12'h00C, 32'hFFFF_FFFF, 32'd0},         // R7 all ones
    {4'd7,  1'b0, 12'h00C, 32'd0,         32'h0000_0103}, // R7 only three bits kept
    {4'd11, 1'b1, 12'h008, 32'hA5A5_0001, 32'd0},         // R11
    {4'd11, 1'b0, 12'h008, 32'd0,         32'hA5A5_0001}, // R11
    {4'd12, 1'b0, 12'h010, 32'd0,         32'd0},         // R12 unmapped
    {4'd12, 1'b0, 12'h040, 32'd0,         32'd0}          // R12 command region reads 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_rd = 1'b1;
    #1 d = h_rdata;
    @(negedge clk);
    h_rd = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); c_cmd_pop = 1'b1;
    @(negedge clk); c_cmd_pop = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); c_rsp_word = d; c_rsp_push = 1'b1;
    @(negedge clk); c_rsp_push = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    rd(12'h000, v); chk("R1 cmd producer", v, 0);
    rd(12'h004, v); chk("R1 rsp consumer", v, 0);
    rd(12'h008, v); chk("R1 urgent", v, 0);
    rd(12'h00C, v); chk("R1 enable", v, 0);
    rd(12'h020, v); chk("R1 cmd consumer", v, 0);
    rd(12'h024, v); chk("R1 rsp producer", v, 0);
    rd(12'h02C, v); chk("R1 status", v, 0);
    rd(12'h400, v); chk("R1 doorbell out", v, 0);
    rd(12'h480, v); chk("R1 doorbell in", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], v);
        chk($sformatf("R%0d vector %0d", VEC[i][80:77], i), v, VEC[i][31:0]);
      end
    end
    chk("R11 c_urgent port", c_urgent, 32'hA5A5_0001);

    do_reset();

    // R4 command ring
    wr(12'h040, 32'h1111);
    wr(12'h044, 32'h2222);
    wr(12'h000, 32'd2);
    chk("R4 avail", {31'b0, c_cmd_avail}, 1);
    chk("R4 head word", c_cmd_word, 32'h1111);
    pop();
    chk("R4 second word", c_cmd_word, 32'h2222);
    rd(12'h020, v); chk("R4 consumer after pop", v, 1);
    pop();
    chk("R4 empty", {31'b0, c_cmd_avail}, 0);
    pop();
    rd(12'h020, v); chk("R4 pop on empty ignored", v, 2);

    wr(12'h0BC, 32'hC0DE_001F);
    wr(12'h000, 32'd1);
    rd(12'h02C, v); chk("R6 command full bit", v & 32'h1, 1);
    repeat (29) pop();
    rd(12'h020, v); chk("R4 consumer at 31", v, 31);
    chk("R4 last slot word", c_cmd_word, 32'hC0DE_001F);
    pop();
    rd(12'h020, v); chk("R4 consumer wraps to 0", v, 0);
    rd(12'h02C, v); chk("R6 not full after drain", v & 32'h1, 0);

    // R10 command consumer event
    wr(12'h00C, 32'h1);
    chk("R10 cleared by status read", {31'b0, irq}, 0);
    pop();
    chk("R10 irq on consumer move", {31'b0, irq}, 1);
    wr(12'h000, 32'd1);
    chk("R10 cleared by producer write", {31'b0, irq}, 0);

    do_reset();

    // R5 response ring
    wr(12'h00C, 32'h2);
    for (int i = 0; i < 15; i++) push(32'h5000 + i);
    chk("R5 no room", {31'b0, c_rsp_room}, 0);
    chk("R10 irq on rsp push", {31'b0, irq}, 1);
    push(32'h0BAD);
    rd(12'h024, v); chk("R5 push when full ignored", v, 15);
    for (int i = 0; i < 15; i++) begin
      rd(12'h0C0 + 12'(4 * i), v);
      chk("R5 response word", v, 32'h5000 + i);
    end
    rd(12'h02C, v); chk("R6 response pending bit", v & 32'h2, 2);
    wr(12'h004, 32'd15);
    chk("R10 cleared by consumer write", {31'b0, irq}, 0);
    rd(12'h02C, v); chk("R6 response drained", v & 32'h2, 0);
    push(32'h600D);
    rd(12'h024, v); chk("R5 producer wraps", v, 0);
    rd(12'h0FC, v); chk("R5 word in slot 15", v, 32'h600D);
    wr(12'h0C0, 32'hDEAD);
    rd(12'h0C0, v); chk("R12 response region write ignored", v, 32'h5000);

    // R6 urgent acknowledge toggling with R10
    wr(12'h00C, 32'h100);
    @(negedge clk); c_urg_ack = 1'b1;
    @(negedge clk); c_urg_ack = 1'b0;
    chk("R10 irq on urgent ack", {31'b0, irq}, 1);
    rd(12'h02C, v); chk("R6 ack bit set", v, 32'h102);
    chk("R10 status read clears", {31'b0, irq}, 0);
    @(negedge clk); c_urg_ack = 1'b1;
    @(negedge clk); c_urg_ack = 1'b0;
    rd(12'h02C, v); chk("R6 ack bit toggles back", v, 32'h002);

    // R8 doorbell toward controller
    wr(12'h400, 32'h1);
    chk("R8 c_doorbell", {31'b0, c_doorbell}, 1);
    rd(12'h400, v); chk("R8 readback", v, 1);
    @(negedge clk); c_db_clr = 1'b1;
    @(negedge clk); c_db_clr = 1'b0;
    chk("R8 controller clear", {31'b0, c_doorbell}, 0);

    // R9 doorbell from controller
    @(negedge clk); c_db_set = 1'b1;
    @(negedge clk); c_db_set = 1'b0;
    rd(12'h480, v); chk("R9 set by controller", v, 1);
    wr(12'h480, 32'h0);
    rd(12'h480, v); chk("R9 host clear", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule